// File: doc/BRIEF.md
# Synchronous Burst SRAM Datapath

This block is a synthesizable model of a synchronous SRAM word array behind a registered input interface. On every rising clock edge it captures the address, the write data, the chip enable and the write controls. It then performs either a read or a byte-masked write, so a new address can be accepted on every cycle. A static mode input selects the read latency. In flow-through mode the array output goes straight to the data pins in the cycle after capture. In pipelined mode the data passes through one more rising-edge output register first.

The output-enable input and the sleep input act asynchronously on a separate drive-enable output, which controls a tristate buffer outside the block. The drive-enable turns off on a single-cycle-deselect schedule. Burst address sequencing is done by a separate generator that feeds the `addr` input. While sleep is high, commands are ignored and the array keeps its contents.

Top module: `syncBurstSram`

## Requirements
- R1: While `rstN` is low, `dOutEn` is 0 and the pipelined output register is cleared to zero. Array contents are not reset.
- R2: With `pipeSel`=0 (flow-through), a read captured at edge k sets `dOutEn` and presents the addressed word on `dOut` after edge k, until edge k+1.
- R3: With `pipeSel`=1 (pipelined), a read captured at edge k presents the addressed word on `dOut`, with `dOutEn` high, after edge k+1, until edge k+2.
- R4: Single-cycle deselect. In pipelined mode, if edge k+1 captures anything other than a read, `dOutEn` falls after edge k+2. In flow-through mode it falls right after the edge that captures the non-read.
- R5: A captured command with `cenN`=0, `gwN`=1, `bweN`=0 and at least one `bselN` bit low writes only the bytes whose `bselN[i]` is 0. Byte i is `dIn[9i+8:9i]`. The other bytes keep their old value.
- R6: `gwN`=0 together with `cenN`=0 writes all four bytes, whatever the values of `bweN` and `bselN`.
- R7: With `cenN`=0 and `gwN`=1, a command is a read when `bweN`=1 or when `bselN` is all ones. It writes nothing.
- R8: A read captured on the edge right after a write to the same address returns the newly written word. Commands may change address on every edge.
- R9: `oeN`=1 forces `dOutEn` to 0 without waiting for a clock edge. It does not disturb any read in flight or the array.
- R10: `sleep`=1 forces `dOutEn` to 0. A command captured while `sleep` is high is ignored, and the array contents are kept.
- R11: In pipelined mode, `dOut` holds its value across every edge that follows a cycle with no read captured.
- R12: With `cenN`=1 (deselect), no write takes place, whatever the write controls say.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the control and output registers |
| pipeSel | input | 1 | Static read mode: 0 flow-through, 1 pipelined |
| cenN | input | 1 | Chip enable, active low, sampled |
| addr | input | ADDR_W | Word address, sampled |
| dIn | input | 36 | Write data, four 9-bit bytes, sampled |
| gwN | input | 1 | All-byte write, active low, sampled |
| bweN | input | 1 | Byte write enable, active low, sampled |
| bselN | input | 4 | Per-byte select, active low, sampled |
| oeN | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Low-power hold, active high, asynchronous on the outputs |
| dOut | output | 36 | Read data toward the external tristate buffer |
| dOutEn | output | 1 | Drive enable for the external tristate buffer |

## Verification
On every cycle, the assertions check the drive-enable schedule: the latency in each mode, the single-cycle turn-off after a non-read, and the asynchronous gating by output enable and sleep. They also check that the pipelined output register stays still when no read was captured. Which bytes a write changes, the override by the all-byte write, and read-after-write on the next edge can only be shown by the bench's scenarios. The bench compares every returned word against a model array that is updated from the command stream.

// File: rtl/sram_pkg.sv
package sram_pkg;

  // Strobes passed from the control path to the datapath.
  typedef struct packed {
    logic wrStb;    // registered write command, applied at the next edge
    logic outLoad;  // registered read command, loads the pipeline register
    logic pipeMode; // static latency selection
  } sramCtrlT;

endpackage

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_pkg::*;
#(
  parameter int NUM_BYTES = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pipeSel,
  input  logic                 cenN,
  input  logic                 gwN,
  input  logic                 bweN,
  input  logic [NUM_BYTES-1:0] bselN,
  input  logic                 oeN,
  input  logic                 sleep,
  output sramCtrlT             ctrl,
  output logic [NUM_BYTES-1:0] wrMask,
  output logic                 dOutEn
);

  logic                 capOk;
  logic                 byteReq;
  logic                 isWr;
  logic                 isRd;
  logic [NUM_BYTES-1:0] nextMask;

  logic                 wrS;
  logic                 rdS;
  logic                 rdS2;
  logic [NUM_BYTES-1:0] maskS;

  // Decode the command presented at this edge.
  always_comb begin
    capOk   = !cenN && !sleep;
    byteReq = !bweN && !(&bselN);
    isWr    = capOk && (!gwN || byteReq);
    isRd    = capOk && !isWr;
    nextMask = '0;
    for (int i = 0; i < NUM_BYTES; i++) begin
      nextMask[i] = !gwN || (!bweN && !bselN[i]);
    end
  end

  // Input register stage for the control path.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrS   <= 1'b0;
      rdS   <= 1'b0;
      maskS <= '0;
    end else begin
      wrS   <= isWr;
      rdS   <= isRd;
      maskS <= nextMask;
    end
  end

  // Second stage tracks reads for the pipelined output register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdS2 <= 1'b0;
    end else begin
      rdS2 <= rdS;
    end
  end

  always_comb begin
    ctrl.wrStb    = wrS;
    ctrl.outLoad  = rdS;
    ctrl.pipeMode = pipeSel;
    wrMask        = maskS;
    dOutEn        = (pipeSel ? rdS2 : rdS) && !oeN && !sleep;
  end

endmodule

// File: rtl/sram_dpath.sv
module sram_dpath
  import sram_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 9
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  sramCtrlT                    ctrl,
  input  logic [NUM_BYTES-1:0]        wrMask,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NUM_BYTES*BYTE_W-1:0] dIn,
  output logic [NUM_BYTES*BYTE_W-1:0] dOut
);

  localparam int WORD_W = NUM_BYTES * BYTE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [ADDR_W-1:0] addrS;
  logic [WORD_W-1:0] dataS;
  logic [WORD_W-1:0] rdWord;
  logic [WORD_W-1:0] pipeReg;

  // Input register stage for address and data.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrS <= '0;
      dataS <= '0;
    end else begin
      addrS <= addr;
      dataS <= dIn;
    end
  end

  // One storage lane per byte; the write uses the previous captured address.
  for (genvar b = 0; b < NUM_BYTES; b++) begin : gLane
    logic [BYTE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (ctrl.wrStb && wrMask[b]) begin
        laneMem[addrS] <= dataS[b*BYTE_W +: BYTE_W];
      end
    end

    assign rdWord[b*BYTE_W +: BYTE_W] = laneMem[addrS];
  end

  // Output register used only in pipelined mode.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeReg <= '0;
    end else if (ctrl.outLoad) begin
      pipeReg <= rdWord;
    end
  end

  assign dOut = ctrl.pipeMode ? pipeReg : rdWord;

endmodule

// File: rtl/syncBurstSram.sv
module syncBurstSram
  import sram_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 9
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        pipeSel,
  input  logic                        cenN,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [NUM_BYTES*BYTE_W-1:0] dIn,
  input  logic                        gwN,
  input  logic                        bweN,
  input  logic [NUM_BYTES-1:0]        bselN,
  input  logic                        oeN,
  input  logic                        sleep,
  output logic [NUM_BYTES*BYTE_W-1:0] dOut,
  output logic                        dOutEn
);

  sramCtrlT             ctrl;
  logic [NUM_BYTES-1:0] wrMask;

  sram_ctrl #(.NUM_BYTES(NUM_BYTES)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .pipeSel(pipeSel),
    .cenN   (cenN),
    .gwN    (gwN),
    .bweN   (bweN),
    .bselN  (bselN),
    .oeN    (oeN),
    .sleep  (sleep),
    .ctrl   (ctrl),
    .wrMask (wrMask),
    .dOutEn (dOutEn)
  );

  sram_dpath #(
    .ADDR_W   (ADDR_W),
    .NUM_BYTES(NUM_BYTES),
    .BYTE_W   (BYTE_W)
  ) dpath_i (
    .clk   (clk),
    .rstN  (rstN),
    .ctrl  (ctrl),
    .wrMask(wrMask),
    .addr  (addr),
    .dIn   (dIn),
    .dOut  (dOut)
  );

endmodule

// File: rtl/sram_chk.sv
module sram_chk #(
  parameter int NUM_BYTES = 4,
  parameter int WORD_W    = 36
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 pipeSel,
  input logic                 cenN,
  input logic                 gwN,
  input logic                 bweN,
  input logic [NUM_BYTES-1:0] bselN,
  input logic                 oeN,
  input logic                 sleep,
  input logic [WORD_W-1:0]    dOut,
  input logic                 dOutEn
);

  logic readCmd;
  logic rdQ1;
  logic rdQ2;

  // Read command as seen at the ports.
  assign readCmd = !cenN && !sleep && gwN && (bweN || (&bselN));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdQ1 <= 1'b0;
      rdQ2 <= 1'b0;
    end else begin
      rdQ1 <= readCmd;
      rdQ2 <= rdQ1;
    end
  end

  AST_OE_SLEEP_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (oeN || sleep) |-> !dOutEn); // R9

  AST_FLOW_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (!pipeSel && !oeN && !sleep) |-> (dOutEn == rdQ1)); // R2

  AST_PIPE_SCD: assert property (@(posedge clk) disable iff (!rstN)
    (pipeSel && !oeN && !sleep) |-> (dOutEn == rdQ2)); // R4

  AST_PIPE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pipeSel && !rdQ1) |=> $stable(dOut)); // R11

endmodule

bind syncBurstSram sram_chk #(
  .NUM_BYTES(NUM_BYTES),
  .WORD_W   (NUM_BYTES*BYTE_W)
) chk_i (
  .clk    (clk),
  .rstN   (rstN),
  .pipeSel(pipeSel),
  .cenN   (cenN),
  .gwN    (gwN),
  .bweN   (bweN),
  .bselN  (bselN),
  .oeN    (oeN),
  .sleep  (sleep),
  .dOut   (dOut),
  .dOutEn (dOutEn)
);

// File: tb/syncBurstSram_tb_top.sv
module syncBurstSram_tb_top;

  localparam int AW = 8;
  localparam int NB = 4;
  localparam int BW = 9;
  localparam int WW = NB * BW;

  logic          clk = 1'b0;
  logic          rstN;
  logic          pipeSel;
  logic          cenN;
  logic [AW-1:0] addr;
  logic [WW-1:0] dIn;
  logic          gwN;
  logic          bweN;
  logic [NB-1:0] bselN;
  logic          oeN;
  logic          sleep;
  logic [WW-1:0] dOut;
  logic          dOutEn;

  int errs = 0;
  int checks = 0;

  logic [WW-1:0] model [1 << AW];
  bit            curRd, prevRd;
  logic [WW-1:0] curData, prevData, pipeHeld;

  always #10 clk = ~clk;

  syncBurstSram #(.ADDR_W(AW), .NUM_BYTES(NB), .BYTE_W(BW)) dut_i (
    .clk(clk), .rstN(rstN), .pipeSel(pipeSel), .cenN(cenN), .addr(addr),
    .dIn(dIn), .gwN(gwN), .bweN(bweN), .bselN(bselN), .oeN(oeN),
    .sleep(sleep), .dOut(dOut), .dOutEn(dOutEn)
  );

  task automatic chk(input bit ok, input string tag, input logic [WW-1:0] act,
                     input logic [WW-1:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit isWrite(input logic c, input logic g, input logic b,
                                 input logic [NB-1:0] s, input logic sl);
    return !c && !sl && (!g || (!b && !(&s)));
  endfunction

  function automatic bit isRead(input logic c, input logic g, input logic b,
                                input logic [NB-1:0] s, input logic sl);
    return !c && !sl && !isWrite(c, g, b, s, sl);
  endfunction

  function automatic logic [WW-1:0] merge(input logic [WW-1:0] old, input logic [WW-1:0] d,
                                          input logic g, input logic [NB-1:0] s);
    logic [WW-1:0] r = old;
    for (int i = 0; i < NB; i++) begin
      if (!g || !s[i]) r[i*BW +: BW] = d[i*BW +: BW];
    end
    return r;
  endfunction

  // One command per clock; outputs checked 5 ns after the capturing edge.
  task automatic step(input logic c, input logic [AW-1:0] a, input logic [WW-1:0] d,
                      input logic g, input logic b, input logic [NB-1:0] s,
                      input logic oe, input logic sl, input string tag);
    bit expEn;
    @(negedge clk);
    cenN = c; addr = a; dIn = d; gwN = g; bweN = b; bselN = s; oeN = oe; sleep = sl;
    prevRd = curRd;
    prevData = curData;
    curRd = isRead(c, g, b, s, sl);
    curData = model[a];
    if (isWrite(c, g, b, s, sl)) model[a] = merge(model[a], d, g, s);
    @(posedge clk);
    #5;
    if (!pipeSel) begin
      expEn = curRd && !oe && !sl;
      chk(dOutEn == expEn, tag, WW'(dOutEn), WW'(expEn));
      if (expEn) chk(dOut == curData, tag, dOut, curData);
    end else begin
      expEn = prevRd && !oe && !sl;
      if (prevRd) pipeHeld = prevData;
      chk(dOutEn == expEn, tag, WW'(dOutEn), WW'(expEn));
      chk(dOut == pipeHeld, tag, dOut, pipeHeld);
    end
  endtask

  task automatic idle(input string tag);
    step(1'b1, '0, '0, 1'b1, 1'b1, '1, 1'b0, 1'b0, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    step(1'b0, a, '0, 1'b1, 1'b1, '1, 1'b0, 1'b0, tag);
  endtask

  task automatic doReset(input logic mode);
    @(negedge clk);
    rstN = 1'b0; pipeSel = mode;
    cenN = 1'b1; addr = '0; dIn = '0; gwN = 1'b1; bweN = 1'b1; bselN = '1;
    oeN = 1'b0; sleep = 1'b0;
    repeat (3) @(posedge clk);
    #5;
    chk(dOutEn == 1'b0, "R1 enable in reset", WW'(dOutEn), '0);
    if (mode) chk(dOut == '0, "R1 pipe register cleared", dOut, '0);
    @(negedge clk);
    rstN = 1'b1;
    curRd = 0; prevRd = 0; pipeHeld = '0; curData = '0; prevData = '0;
  endtask

  task automatic randomRun(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      logic c  = ($urandom % 10) == 0;
      logic [AW-1:0] a = AW'($urandom % 6);
      logic [WW-1:0] d = {$urandom, $urandom};
      logic g  = ($urandom % 4) != 0;
      logic b  = ($urandom % 2) != 0;
      logic [NB-1:0] s = NB'($urandom);
      logic oe = ($urandom % 10) == 0;
      logic sl = ($urandom % 20) == 0;
      step(c, a, d, g, b, s, oe, sl, tag);
    end
  endtask

  initial begin
    #(20 * 200000);
    errs++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    // Pipelined mode
    doReset(1'b1);
    for (int a = 0; a < (1 << AW); a++) begin
      step(1'b0, AW'(a), {$urandom, $urandom}, 1'b0, 1'b1, '1, 1'b0, 1'b0, "R6 fill");
    end
    step(1'b0, 8'd3, 36'h1_2345_6789, 1'b0, 1'b0, 4'b0101, 1'b0, 1'b0, "R6 override");
    rd(8'd3, "R6 readback");
    rd(8'd5, "R3 read");
    idle("R3 data one edge later");
    idle("R4 pipe deselect off");
    step(1'b0, 8'd7, 36'hA_BCDE_F012, 1'b1, 1'b0, 4'b1010, 1'b0, 1'b0, "R5 byte write");
    rd(8'd7, "R5 read");
    idle("R5 masked result");
    step(1'b0, 8'd7, 36'h0_0000_0000, 1'b1, 1'b0, 4'b1111, 1'b0, 1'b0, "R7 no-byte read");
    rd(8'd7, "R7 unchanged");
    idle("R7 check");
    step(1'b1, 8'd8, 36'hF_FFFF_FFFF, 1'b0, 1'b0, 4'b0000, 1'b0, 1'b0, "R12 deselect write");
    rd(8'd8, "R12 read");
    idle("R12 unchanged");
    rd(8'd8, "R9 read");
    step(1'b1, '0, '0, 1'b1, 1'b1, '1, 1'b1, 1'b0, "R9 oe off");
    step(1'b0, 8'd9, 36'h5_5555_5555, 1'b0, 1'b1, '1, 1'b0, 1'b1, "R10 sleep write");
    rd(8'd9, "R10 read");
    idle("R10 contents kept");
    step(1'b0, 8'd10, 36'h3_3333_3333, 1'b0, 1'b1, '1, 1'b0, 1'b0, "R8 write");
    rd(8'd10, "R8 read next edge");
    idle("R8 new data");
    idle("R11 hold");
    randomRun(400, "R8 R11 pipe random");
    // Flow-through mode (array keeps its contents over reset)
    doReset(1'b0);
    rd(8'd10, "R2 flow read");
    idle("R4 flow deselect off");
    step(1'b0, 8'd11, 36'h7_0F0F_0F0F, 1'b1, 1'b0, 4'b0110, 1'b0, 1'b0, "R5 flow byte write");
    rd(8'd11, "R8 flow read after write");
    step(1'b0, 8'd11, '0, 1'b1, 1'b1, '1, 1'b1, 1'b0, "R9 flow oe off");
    randomRun(400, "R2 R5 flow random");
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule